// File: doc/BRIEF.md
# Cascadable Delay-Select Latch Controller

This block is the digital control section for a chain of programmable delay stages. Each stage keeps an 8-bit control word. The low seven bits choose a fine delay in quarter-gate steps. The top bit asks for a handover to the next stage. Each stage reports its effective tap count in quarter-gate units, and the chain reports the sum of all the stage counts. The analog delay elements are not part of this block.

All stages share one fine-code bus. Each stage except the last also has its own cascade line. That line goes into the stage's top latch and also drives the stage to maximum. A stage whose top bit is low holds the next stage at minimum. A stage whose top bit is high releases the next stage, which then follows the shared bus. The maximum setting clears the two lowest fine latches, sets all the other latches, and selects one extra gate. The maximum stage therefore reports exactly 32 gates, so the total never drops at a handover.

The control words are captured on the clock while the load enable is high and held while it is low. The overrides act on the reported value at once, and they rewrite the stored word at the next clock edge.

Top module: `dly_chain_top`

## Requirements
- R1: After reset every stage reports 0 and the total is 0.
- R2: While load is enabled and the first stage has no override and no cascade line set, at each clock edge the first stage stores the fine code. From then on it reports that code (0 to 127) as its tap count.
- R3: While load is disabled, changes on the fine-code bus and on the last stage's inputs leave every tap count unchanged.
- R4: A stage whose cascade line is high reports 128. This is the stored pattern 1111100 on the fine bits plus one extra gate of 4 quarter units.
- R5: A stage whose predecessor's top bit is low reports 0 whatever the fine-code bus holds.
- R6: A stage whose predecessor's top bit is high and which has no cascade line of its own set loads and reports the fine code.
- R7: When the minimum and maximum overrides of a stage are both active, the minimum wins and the stage reports 0.
- R8: The total equals the sum of the stage counts. For a 3-stage chain driven with the thermometer cascade codes 00, 10 and 11 (first line, second line), the total equals level*128 + fine code and rises strictly along that combined code.
- R9: After an override is released while load is disabled, the stage keeps reporting the value the override forced.
- R10: The external minimum and maximum inputs act as the first stage's overrides, with the same priority as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, clears all words |
| loadEn | input | 1 | Latch enable: stores the control words when high |
| fineCode | input | FINE_W | Shared fine-delay code |
| cascCtl | input | NUM_STAGES-1 | One cascade line per stage except the last (bit k belongs to stage k) |
| headSetMin | input | 1 | External minimum override of the first stage |
| headSetMax | input | 1 | External maximum override of the first stage |
| tapCounts | output | NUM_STAGES*(FINE_W+1) | Tap count per stage, stage k in slice k |
| totalTaps | output | TOTAL_W | Sum of all stage tap counts |

## Verification
The hardest state to reach is a stage that keeps a forced word after its override has gone away. The stage has to be overridden across a clock edge while load is disabled, and the override then released without any load. The bench builds this by raising the first cascade line with load low, clocking once, and dropping the line again. It then checks that the first stage still reports maximum and still releases its successor. The conflicting case, where both overrides are active together, comes from setting a later cascade line while an earlier one is low. This case is swept over every fine code.

// File: rtl/dly_chain_pkg.sv
package dly_chain_pkg;

  typedef struct packed {
    logic forceMin;
    logic forceMax;
    logic load;
  } stageStrobe_t;

endpackage

// File: rtl/dly_stage_ctrl.sv
module dly_stage_ctrl
  import dly_chain_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         loadEn,
  input  logic         extMin,
  input  logic         extMax,
  output stageStrobe_t strobe
);

  always_comb begin
    strobe.forceMin = extMin;
    strobe.forceMax = extMax && !extMin;
    strobe.load     = loadEn && !extMin && !extMax;
  end

  // R7
  override_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.forceMin, strobe.forceMax, strobe.load}));

endmodule

// File: rtl/dly_stage_latch.sv
module dly_stage_latch
  import dly_chain_pkg::*;
#(
  parameter int FINE_W = 7,
  localparam int TAP_W = FINE_W + 1,
  localparam int FULL  = 2 ** FINE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  stageStrobe_t     strobe,
  input  logic [FINE_W-1:0] fineCode,
  input  logic             cascIn,
  output logic [TAP_W-1:0] tapCount,
  output logic             cascOut
);

  localparam logic [TAP_W-1:0] MAX_WORD = {1'b1, {(FINE_W-2){1'b1}}, 2'b00};

  logic [TAP_W-1:0] storedWord;
  logic [TAP_W-1:0] effWord;

  always_ff @(posedge clk) begin
    if (!rst_n)               storedWord <= '0;
    else if (strobe.forceMin) storedWord <= '0;
    else if (strobe.forceMax) storedWord <= MAX_WORD;
    else if (strobe.load)     storedWord <= {cascIn, fineCode};
  end

  always_comb begin
    if (strobe.forceMin)      effWord = '0;
    else if (strobe.forceMax) effWord = MAX_WORD;
    else                      effWord = storedWord;
  end

  assign cascOut  = effWord[TAP_W-1];
  assign tapCount = effWord[TAP_W-1] ? TAP_W'(FULL)
                                     : {1'b0, effWord[FINE_W-1:0]};

  // R5
  min_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.forceMin |-> (tapCount == '0 && !cascOut));

  // R4
  max_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.forceMax |-> (tapCount == TAP_W'(FULL) && cascOut));

  // R3
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.load && !strobe.forceMin && !strobe.forceMax) |=> $stable(storedWord));

  // R8
  tap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tapCount <= TAP_W'(FULL));

endmodule

// File: rtl/dly_chain_top.sv
module dly_chain_top
  import dly_chain_pkg::*;
#(
  parameter int NUM_STAGES = 3,
  parameter int FINE_W     = 7,
  localparam int TAP_W     = FINE_W + 1,
  localparam int FULL      = 2 ** FINE_W,
  localparam int TOTAL_W   = $clog2(NUM_STAGES * FULL + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        loadEn,
  input  logic [FINE_W-1:0]           fineCode,
  input  logic [NUM_STAGES-2:0]       cascCtl,
  input  logic                        headSetMin,
  input  logic                        headSetMax,
  output logic [NUM_STAGES*TAP_W-1:0] tapCounts,
  output logic [TOTAL_W-1:0]          totalTaps
);

  logic [NUM_STAGES-1:0] cascHi;
  logic [NUM_STAGES-1:0] stageMin;
  logic [NUM_STAGES-1:0] stageMax;
  logic [NUM_STAGES-1:0] stageD7;

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    stageStrobe_t strobe;
    logic [TAP_W-1:0] tapK;

    if (k == 0) begin : g_head
      assign stageMin[k] = headSetMin;
      assign stageMax[k] = headSetMax | cascCtl[0];
      assign stageD7[k]  = cascCtl[0];
    end else if (k < NUM_STAGES - 1) begin : g_mid
      assign stageMin[k] = !cascHi[k-1];
      assign stageMax[k] = cascCtl[k];
      assign stageD7[k]  = cascCtl[k];
    end else begin : g_tail
      assign stageMin[k] = !cascHi[k-1];
      assign stageMax[k] = 1'b0;
      assign stageD7[k]  = 1'b0;
    end

    dly_stage_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .loadEn (loadEn),
      .extMin (stageMin[k]),
      .extMax (stageMax[k]),
      .strobe (strobe)
    );

    dly_stage_latch #(.FINE_W(FINE_W)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe   (strobe),
      .fineCode (fineCode),
      .cascIn   (stageD7[k]),
      .tapCount (tapK),
      .cascOut  (cascHi[k])
    );

    assign tapCounts[k*TAP_W +: TAP_W] = tapK;

    if (k > 0) begin : g_chk
      // R5
      chain_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cascHi[k-1] |-> (tapK == '0));
    end
  end

  always_comb begin
    totalTaps = '0;
    for (int k = 0; k < NUM_STAGES; k++)
      totalTaps = totalTaps + TOTAL_W'(tapCounts[k*TAP_W +: TAP_W]);
  end

  // R8
  total_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    totalTaps <= TOTAL_W'(NUM_STAGES * FULL));

endmodule

// File: tb/dly_chain_top_tb.sv
module dly_chain_top_tb;

  localparam int N     = 3;
  localparam int FW    = 7;
  localparam int TW    = FW + 1;
  localparam int TOTW  = $clog2(N * 128 + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic loadEn;
  logic [FW-1:0] fineCode;
  logic [N-2:0] cascCtl;
  logic headSetMin, headSetMax;
  logic [N*TW-1:0] tapCounts;
  logic [TOTW-1:0] totalTaps;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dly_chain_top #(.NUM_STAGES(N), .FINE_W(FW)) u_dut (
    .clk(clk), .rst_n(rst_n), .loadEn(loadEn), .fineCode(fineCode),
    .cascCtl(cascCtl), .headSetMin(headSetMin), .headSetMax(headSetMax),
    .tapCounts(tapCounts), .totalTaps(totalTaps)
  );

  task automatic expectChain(string req, int e0, int e1, int e2);
    int a0, a1, a2, at;
    a0 = int'(tapCounts[0*TW +: TW]);
    a1 = int'(tapCounts[1*TW +: TW]);
    a2 = int'(tapCounts[2*TW +: TW]);
    at = int'(totalTaps);
    checks++;
    if (a0 != e0 || a1 != e1 || a2 != e2 || at != e0 + e1 + e2) begin
      fails++;
      $display("FAIL %s: taps=%0d/%0d/%0d total=%0d expected %0d/%0d/%0d total=%0d",
               req, a0, a1, a2, at, e0, e1, e2, e0 + e1 + e2);
    end
  endtask

  // drive at negedge, clock once, sample at the next negedge
  task automatic step(logic ld, int code, logic [N-2:0] cc, logic hmin, logic hmax);
    loadEn = ld; fineCode = FW'(code); cascCtl = cc;
    headSetMin = hmin; headSetMax = hmax;
    @(negedge clk);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog: cycles=%0d expected completion", cycles);
        done = 1'b1;
      end
    end
  end

  initial begin
    int prevTotal;
    rst_n = 1'b0; loadEn = 1'b0; fineCode = '0; cascCtl = '0;
    headSetMin = 1'b0; headSetMax = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    expectChain("R1", 0, 0, 0);

    // R2 single loads
    step(1'b1, 45, 2'b00, 1'b0, 1'b0); expectChain("R2", 45, 0, 0);
    step(1'b1, 127, 2'b00, 1'b0, 1'b0); expectChain("R2", 127, 0, 0);

    // R3 bus and tail inputs ignored when load low
    step(1'b0, 3, 2'b00, 1'b0, 1'b0); expectChain("R3", 127, 0, 0);
    step(1'b0, 90, 2'b00, 1'b0, 1'b0); expectChain("R3", 127, 0, 0);

    // R8 R4 R5 R6: thermometer sweep, total monotonic
    prevTotal = -1;
    for (int lvl = 0; lvl < N; lvl++) begin
      for (int a = 0; a < 128; a++) begin
        logic [N-2:0] cc;
        int e0, e1, e2, tot;
        cc = {(lvl >= 2), (lvl >= 1)};
        step(1'b1, a, cc, 1'b0, 1'b0);
        e0 = (lvl >= 1) ? 128 : a;
        e1 = (lvl == 0) ? 0 : ((lvl >= 2) ? 128 : a);
        e2 = (lvl >= 2) ? a : 0;
        expectChain("R8/R4/R5/R6", e0, e1, e2);
        tot = int'(totalTaps);
        checks++;
        if (tot != lvl * 128 + a || tot <= prevTotal) begin
          fails++;
          $display("FAIL R8 monotonic: total=%0d expected %0d (prev %0d)",
                   tot, lvl * 128 + a, prevTotal);
        end
        prevTotal = tot;
      end
    end

    // R7: later cascade line without earlier one -> min wins on stage 1
    for (int a = 0; a < 128; a++) begin
      step(1'b1, a, 2'b10, 1'b0, 1'b0);
      expectChain("R7", a, 0, 0);
    end

    // R9: override across an edge with load low, then released
    step(1'b1, 5, 2'b00, 1'b0, 1'b0); expectChain("R2", 5, 0, 0);
    step(1'b0, 5, 2'b01, 1'b0, 1'b0); expectChain("R9", 128, 0, 0);
    step(1'b0, 5, 2'b00, 1'b0, 1'b0); expectChain("R9", 128, 0, 0);
    step(1'b1, 7, 2'b00, 1'b0, 1'b0); expectChain("R9", 7, 0, 0);

    // R10: external overrides on the head stage
    step(1'b1, 9, 2'b00, 1'b0, 1'b1); expectChain("R10", 128, 9, 0);
    step(1'b1, 9, 2'b00, 1'b1, 1'b1); expectChain("R10", 0, 0, 0);
    step(1'b1, 9, 2'b00, 1'b1, 1'b0); expectChain("R10", 0, 0, 0);
    step(1'b1, 9, 2'b00, 1'b0, 1'b0); expectChain("R10", 9, 0, 0);

    // R1 again: reset from a loaded state
    step(1'b1, 60, 2'b11, 1'b0, 1'b0); expectChain("R8", 128, 128, 60);
    rst_n = 1'b0; loadEn = 1'b0; cascCtl = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expectChain("R1", 0, 0, 0);

    done = 1'b1;
  end

  initial begin
    wait (done);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule